// File: doc/BRIEF.md
# Descriptor-Driven Bus-Master Disk DMA Channel

This block is a single-channel DMA engine that moves 16-bit words between system memory and the data port of an ATA disk drive. Software writes the base address of a table of 8-byte descriptors into a pointer register. It then sets the direction bit and the go bit in the command register, after it has already issued the drive command. The engine fetches each descriptor and streams the described buffer to or from the drive, one word per drive request. When the entry flagged as last is used up, the engine stops and raises its interrupt.

A descriptor holds two 32-bit words. The first word is the buffer byte address, and bit 0 of that address is ignored. In the second word, bits 15:0 are the byte count, where 0 means 65536 bytes, and bit 31 marks the final entry. The status byte combines three things: an activity flag that software can only read, error and interrupt flags that software clears by writing 1, and two drive-capability flags that software reads and writes freely. On the memory side and the drive side the engine uses plain valid/ready style handshakes.

Top module: `ide_bm_dma`

## Requirements
- R1: After reset the command, status and pointer registers all read 0. `mem_valid`, `drv_ack` and `irq` are low.
- R2: Writing the command register (offset 0) with bit 0 set, while that bit was clear, starts the engine. On the next cycle it requests a memory read at the address held in the pointer register (offset 4, 32 bits).
- R3: With command bit 3 set, each word accepted from the drive (`drv_req` high answered by `drv_ack`) is written to memory at consecutive even addresses. The write data is in `mem_wdata[15:0]`.
- R4: With command bit 3 clear, each memory word read (`mem_rdata[15:0]`) is presented on `drv_dout` with `drv_ack`, in ascending address order.
- R5: The byte count in bits 15:0 of a descriptor's second word sets how many bytes that entry moves. A count of 0 moves 65536 bytes. Bit 0 of the buffer address is treated as 0.
- R6: When the entry with bit 31 of its second word set is exhausted, the engine stops. Status bits [2:0] then read 100b (interrupt set, error and active clear) and `irq` is high.
- R7: In the status register (offset 2), writing 1 to bit 1 (error) or bit 2 (interrupt) clears that bit. Writing 0 leaves it unchanged.
- R8: Status bits 5 and 6 read back what software last wrote to them. A transfer does not change them.
- R9: Clearing command bit 0 during a transfer makes status bit 0 read 0 and drops `mem_valid` in the cycle after the write. No further memory or drive traffic follows, and interrupt stays clear.
- R10: A memory access answered with `mem_err` sets status bit 1, clears bit 0 and halts the engine. No later memory access occurs and interrupt stays clear.
- R11: If the drive still requests data after the table is finished and bit 0 is still set, status bit 1 is set.
- R12: The reserved offsets 1 and 3 read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data (word in bits 15:0) |
| mem_ready | input | 1 | Memory accepts/completes the request this cycle |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |
| mem_err | input | 1 | Error response, valid with `mem_ready` |
| drv_req | input | 1 | Drive requests a word transfer |
| drv_ack | output | 1 | Engine takes/gives a word this cycle |
| drv_din | input | 16 | Word from the drive |
| drv_dout | output | 16 | Word to the drive |
| irq | output | 1 | Interrupt, equal to status bit 2 |

## Verification
The hardest case to reach is the entry whose count is zero. It only shows up after 32768 word moves, so the bench builds a one-entry table with count 0 and runs a drive model that keeps requesting without pause. It then checks the number of writes and the final address. The abort and the memory fault also have to land in the middle of a transfer. For these, the bench writes the command register a fixed number of cycles after start, and injects an error response at one chosen buffer address. In both cases it confirms that memory traffic stops.

// File: rtl/ide_bm_pkg.sv
package ide_bm_pkg;
  localparam logic [2:0] OFS_CMD  = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd2;
  localparam logic [2:0] OFS_PTR  = 3'd4;

  localparam int CMD_GO    = 0;
  localparam int CMD_TOMEM = 3;
  localparam int ST_ACT    = 0;
  localparam int ST_ERR    = 1;
  localparam int ST_INT    = 2;
  localparam int ST_CAP0   = 5;
  localparam int ST_CAP1   = 6;

  localparam int DESC_LAST  = 31;
  localparam int DESC_BYTES = 8;
  localparam int WORD_BYTES = 2;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_DESC0 = 3'd1,
    S_DESC1 = 3'd2,
    S_MEM   = 3'd3,
    S_DRV   = 3'd4,
    S_STOP  = 3'd5
  } bm_state_e;
endpackage

// File: rtl/ide_bm_regs.sv
module ide_bm_regs
  import ide_bm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              active_i,
  input  logic              set_err_i,
  input  logic              set_intr_i,
  output logic [31:0]       reg_rdata,
  output logic              start_o,
  output logic              to_mem_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              launch_o,
  output logic              irq_o
);
  logic              start_q, start_d;
  logic              dir_q, dir_d;
  logic              err_q, err_d;
  logic              intr_q, intr_d;
  logic [1:0]        cap_q, cap_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              wr_cmd, wr_stat, wr_ptr;
  logic [31:0]       ptr_ext;

  assign wr_cmd  = reg_we && (reg_addr == OFS_CMD);
  assign wr_stat = reg_we && (reg_addr == OFS_STAT);
  assign wr_ptr  = reg_we && (reg_addr == OFS_PTR);

  always_comb begin
    start_d = reg_wdata[CMD_GO];
    dir_d   = reg_wdata[CMD_TOMEM];
    ptr_d   = reg_wdata[ADDR_W-1:0];
    cap_d   = {reg_wdata[ST_CAP1], reg_wdata[ST_CAP0]};
    err_d   = set_err_i  | (err_q  & ~(wr_stat & reg_wdata[ST_ERR]));
    intr_d  = set_intr_i | (intr_q & ~(wr_stat & reg_wdata[ST_INT]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      dir_q   <= 1'b0;
      ptr_q   <= '0;
      cap_q   <= '0;
      err_q   <= 1'b0;
      intr_q  <= 1'b0;
    end else begin
      if (wr_cmd) begin
        start_q <= start_d;
        dir_q   <= dir_d;
      end
      if (wr_ptr)  ptr_q <= ptr_d;
      if (wr_stat) cap_q <= cap_d;
      err_q  <= err_d;
      intr_q <= intr_d;
    end
  end

  always_comb begin
    ptr_ext = '0;
    ptr_ext[ADDR_W-1:0] = ptr_q;
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_CMD: begin
        reg_rdata[CMD_GO]    = start_q;
        reg_rdata[CMD_TOMEM] = dir_q;
      end
      OFS_STAT: begin
        reg_rdata[ST_ACT]  = active_i;
        reg_rdata[ST_ERR]  = err_q;
        reg_rdata[ST_INT]  = intr_q;
        reg_rdata[ST_CAP0] = cap_q[0];
        reg_rdata[ST_CAP1] = cap_q[1];
      end
      OFS_PTR: reg_rdata = ptr_ext;
      default: reg_rdata = '0;
    endcase
  end

  assign start_o  = start_q;
  assign to_mem_o = dir_q;
  assign ptr_o    = ptr_q;
  assign launch_o = wr_cmd && reg_wdata[CMD_GO] && !start_q;
  assign irq_o    = intr_q;

  // R8
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> $stable(cap_q));

  // R7
  w1c_intr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && reg_wdata[ST_INT] && !set_intr_i) |=> !intr_q);

  // R7
  w1c_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && reg_wdata[ST_ERR] && !set_err_i) |=> !err_q);
endmodule

// File: rtl/ide_bm_cnt.sv
module ide_bm_cnt
  import ide_bm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic              lo_ld_i,
  input  logic              hi_ld_i,
  input  logic              step_i,
  input  logic [31:0]       word_i,
  output logic [ADDR_W-1:0] dptr_o,
  output logic [ADDR_W-1:0] baddr_o,
  output logic              last_word_o,
  output logic              last_desc_o
);
  localparam int CNT_W = 17;
  localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(1) << 16;
  localparam logic [CNT_W-1:0]  WSTEP    = CNT_W'(WORD_BYTES);
  localparam logic [ADDR_W-1:0] ASTEP    = ADDR_W'(WORD_BYTES);
  localparam logic [ADDR_W-1:0] DSTEP    = ADDR_W'(DESC_BYTES);

  logic [ADDR_W-1:0] dptr_q, dptr_d;
  logic [ADDR_W-1:0] baddr_q, baddr_d;
  logic [CNT_W-1:0]  bytes_q, bytes_d;
  logic              last_q, last_d;
  logic              dptr_en, baddr_en, bytes_en;
  logic              unused_bit0;

  assign unused_bit0 = word_i[0];

  always_comb begin
    dptr_en  = launch_i | hi_ld_i;
    dptr_d   = launch_i ? ptr_i : dptr_q + DSTEP;
    baddr_en = lo_ld_i | step_i;
    baddr_d  = lo_ld_i ? {word_i[ADDR_W-1:1], 1'b0} : baddr_q + ASTEP;
    bytes_en = hi_ld_i | step_i;
    if (hi_ld_i)
      bytes_d = (word_i[15:0] == 16'h0000) ? FULL_CNT : {1'b0, word_i[15:0]};
    else
      bytes_d = bytes_q - WSTEP;
    last_d = word_i[DESC_LAST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dptr_q  <= '0;
      baddr_q <= '0;
      bytes_q <= '0;
      last_q  <= 1'b0;
    end else begin
      if (dptr_en)  dptr_q  <= dptr_d;
      if (baddr_en) baddr_q <= baddr_d;
      if (bytes_en) bytes_q <= bytes_d;
      if (hi_ld_i)  last_q  <= last_d;
    end
  end

  assign dptr_o      = dptr_q;
  assign baddr_o     = baddr_q;
  assign last_word_o = (bytes_q <= WSTEP);
  assign last_desc_o = last_q;

  // R5
  zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_ld_i && word_i[15:0] == 16'h0000) |=> (bytes_q == FULL_CNT));

  // R5
  addr_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_ld_i |=> (baddr_q[0] == 1'b0));
endmodule

// File: rtl/ide_bm_fsm.sv
module ide_bm_fsm
  import ide_bm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  logic              start_i,
  input  logic              to_mem_i,
  input  logic              mem_ready_i,
  input  logic              mem_err_i,
  input  logic [15:0]       mem_rdata_i,
  input  logic              drv_req_i,
  input  logic [15:0]       drv_din_i,
  input  logic              last_word_i,
  input  logic              last_desc_i,
  input  logic [ADDR_W-1:0] dptr_i,
  input  logic [ADDR_W-1:0] baddr_i,
  output logic              mem_valid_o,
  output logic              mem_write_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [15:0]       hold_o,
  output logic              drv_ack_o,
  output logic              active_o,
  output logic              set_err_o,
  output logic              set_intr_o,
  output logic              lo_ld_o,
  output logic              hi_ld_o,
  output logic              step_o
);
  localparam logic [ADDR_W-1:0] HI_OFS = ADDR_W'(4);

  bm_state_e   state_q, state_d;
  logic [15:0] hold_q, hold_d;
  logic        hold_en;
  logic        busy, mem_done;

  assign busy        = (state_q == S_DESC0) || (state_q == S_DESC1) ||
                       (state_q == S_MEM)   || (state_q == S_DRV);
  assign active_o    = busy && start_i;
  assign mem_valid_o = start_i && ((state_q == S_DESC0) || (state_q == S_DESC1) ||
                                   (state_q == S_MEM));
  assign mem_write_o = (state_q == S_MEM) && to_mem_i;
  assign drv_ack_o   = start_i && (state_q == S_DRV) && drv_req_i;
  assign mem_done    = mem_valid_o && mem_ready_i;

  always_comb begin
    unique case (state_q)
      S_DESC0: mem_addr_o = dptr_i;
      S_DESC1: mem_addr_o = dptr_i + HI_OFS;
      default: mem_addr_o = baddr_i;
    endcase
  end

  always_comb begin
    state_d    = state_q;
    hold_d     = to_mem_i ? drv_din_i : mem_rdata_i;
    hold_en    = 1'b0;
    set_err_o  = 1'b0;
    set_intr_o = 1'b0;
    lo_ld_o    = 1'b0;
    hi_ld_o    = 1'b0;
    step_o     = 1'b0;
    unique case (state_q)
      S_IDLE: if (launch_i) state_d = S_DESC0;
      S_DESC0: if (mem_done) begin
        if (mem_err_i) begin
          set_err_o = 1'b1;
          state_d   = S_STOP;
        end else begin
          lo_ld_o = 1'b1;
          state_d = S_DESC1;
        end
      end
      S_DESC1: if (mem_done) begin
        if (mem_err_i) begin
          set_err_o = 1'b1;
          state_d   = S_STOP;
        end else begin
          hi_ld_o = 1'b1;
          state_d = to_mem_i ? S_DRV : S_MEM;
        end
      end
      S_MEM: if (mem_done) begin
        if (mem_err_i) begin
          set_err_o = 1'b1;
          state_d   = S_STOP;
        end else if (to_mem_i) begin
          step_o = 1'b1;
          if (!last_word_i)     state_d = S_DRV;
          else if (last_desc_i) begin
            set_intr_o = 1'b1;
            state_d    = S_STOP;
          end else              state_d = S_DESC0;
        end else begin
          hold_en = 1'b1;
          state_d = S_DRV;
        end
      end
      S_DRV: if (drv_ack_o) begin
        if (to_mem_i) begin
          hold_en = 1'b1;
          state_d = S_MEM;
        end else begin
          step_o = 1'b1;
          if (!last_word_i)     state_d = S_MEM;
          else if (last_desc_i) begin
            set_intr_o = 1'b1;
            state_d    = S_STOP;
          end else              state_d = S_DESC0;
        end
      end
      S_STOP: begin
        if (!start_i)       state_d = launch_i ? S_DESC0 : S_IDLE;
        else if (drv_req_i) set_err_o = 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
    if (busy && !start_i) state_d = launch_i ? S_DESC0 : S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      if (hold_en) hold_q <= hold_d;
    end
  end

  assign hold_o = hold_q;

  // R9
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start_i && !launch_i) |=> (state_q == S_IDLE));

  // R6
  done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_intr_o |=> (!active_o && state_q == S_STOP));

  // R3
  tomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_ack_o && to_mem_i) |=> (!start_i || (mem_valid_o && mem_write_o)));

  // R11
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_STOP) |-> !mem_valid_o && !drv_ack_o);
endmodule

// File: rtl/ide_bm_dma.sv
module ide_bm_dma
  import ide_bm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_err,
  input  logic              drv_req,
  output logic              drv_ack,
  input  logic [15:0]       drv_din,
  output logic [15:0]       drv_dout,
  output logic              irq
);
  logic              start_w, to_mem_w, launch_w, active_w;
  logic              set_err_w, set_intr_w;
  logic              lo_ld_w, hi_ld_w, step_w;
  logic              last_word_w, last_desc_w;
  logic [ADDR_W-1:0] ptr_w, dptr_w, baddr_w;
  logic [15:0]       hold_w;

  ide_bm_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .active_i(active_w), .set_err_i(set_err_w), .set_intr_i(set_intr_w),
    .reg_rdata(reg_rdata), .start_o(start_w), .to_mem_o(to_mem_w),
    .ptr_o(ptr_w), .launch_o(launch_w), .irq_o(irq)
  );

  ide_bm_cnt #(.ADDR_W(ADDR_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .launch_i(launch_w), .ptr_i(ptr_w),
    .lo_ld_i(lo_ld_w), .hi_ld_i(hi_ld_w), .step_i(step_w),
    .word_i(mem_rdata),
    .dptr_o(dptr_w), .baddr_o(baddr_w),
    .last_word_o(last_word_w), .last_desc_o(last_desc_w)
  );

  ide_bm_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .launch_i(launch_w), .start_i(start_w), .to_mem_i(to_mem_w),
    .mem_ready_i(mem_ready), .mem_err_i(mem_err), .mem_rdata_i(mem_rdata[15:0]),
    .drv_req_i(drv_req), .drv_din_i(drv_din),
    .last_word_i(last_word_w), .last_desc_i(last_desc_w),
    .dptr_i(dptr_w), .baddr_i(baddr_w),
    .mem_valid_o(mem_valid), .mem_write_o(mem_write), .mem_addr_o(mem_addr),
    .hold_o(hold_w), .drv_ack_o(drv_ack), .active_o(active_w),
    .set_err_o(set_err_w), .set_intr_o(set_intr_w),
    .lo_ld_o(lo_ld_w), .hi_ld_o(hi_ld_w), .step_o(step_w)
  );

  assign mem_wdata = {16'h0000, hold_w};
  assign drv_dout  = hold_w;

  // R2
  launch_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_w |=> (mem_valid && !mem_write && mem_addr == $past(ptr_w)));

  // R10
  mem_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_err) |=> (!mem_valid && !active_w && !irq));
endmodule

// File: tb/sim_ide_bm_dma.sv
module sim_ide_bm_dma;
  localparam logic [31:0] DT = 32'h0000_1000;

  logic        clk, rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_valid, mem_write, mem_ready, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        drv_req, drv_ack;
  logic [15:0] drv_din, drv_dout;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] dmem [0:15];
  logic        err_en;
  logic [31:0] err_addr;
  int          quota;
  int          given = 0;
  int          wr_cnt = 0;
  int          rd_cnt = 0;
  logic [31:0] wlog_a [0:63];
  logic [15:0] wlog_d [0:63];
  logic [31:0] rdlog_a [0:63];
  logic [15:0] rlog [0:63];
  logic [31:0] wr_last;

  ide_bm_dma u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .mem_err(mem_err), .drv_req(drv_req), .drv_ack(drv_ack),
    .drv_din(drv_din), .drv_dout(drv_dout), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [15:0] fdat(logic [31:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  always_comb begin
    mem_ready = mem_valid;
    mem_err   = mem_valid && err_en && (mem_addr == err_addr);
    if (mem_addr[31:6] == DT[31:6]) mem_rdata = dmem[mem_addr[5:2]];
    else                            mem_rdata = {16'h0000, fdat(mem_addr)};
  end

  assign drv_req = (given < quota);
  assign drv_din = 16'h1000 + given[15:0];

  always @(posedge clk) begin
    if (mem_valid && mem_ready && !mem_err) begin
      if (mem_write) begin
        wlog_a[wr_cnt[5:0]] <= mem_addr;
        wlog_d[wr_cnt[5:0]] <= mem_wdata[15:0];
        wr_last <= mem_addr;
        wr_cnt  <= wr_cnt + 1;
      end else begin
        rdlog_a[rd_cnt[5:0]] <= mem_addr;
        rd_cnt <= rd_cnt + 1;
      end
    end
    if (drv_ack) begin
      rlog[given[5:0]] <= drv_dout;
      given <= given + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_irq(input int lim, input string req);
    int n;
    n = 0;
    while (!irq && n < lim) begin
      @(negedge clk);
      n++;
    end
    chk(req, {31'b0, irq}, 32'd1);
  endtask

  task automatic cleanup();
    wr(3'd0, 32'h0);
    wr(3'd2, 32'h06);
    quota  = given;
    err_en = 1'b0;
  endtask

  task automatic launch(input logic tomem);
    wr(3'd4, DT);
    wr(3'd0, {28'h0, tomem, 3'b001});
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd0, v); chk("R1 cmd", v, 32'h0);
    rd(3'd2, v); chk("R1 status", v, 32'h0);
    rd(3'd4, v); chk("R1 ptr", v, 32'h0);
    chk("R1 outputs", {29'b0, mem_valid, drv_ack, irq}, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(3'd1, 32'hFF);
    wr(3'd3, 32'hFF);
    rd(3'd1, v); chk("R12 offset1", v, 32'h0);
    rd(3'd3, v); chk("R12 offset3", v, 32'h0);
    rd(3'd2, v); chk("R12 status untouched", v, 32'h0);
    wr(3'd4, 32'h1234_5678);
    rd(3'd4, v); chk("R2 ptr readback", v, 32'h1234_5678);
  endtask

  task automatic t_to_mem();
    logic [31:0] v;
    logic [31:0] ea [0:5];
    int wb, gb, rb;
    ea[0] = 32'h2000; ea[1] = 32'h2002; ea[2] = 32'h3000;
    ea[3] = 32'h4000; ea[4] = 32'h4002; ea[5] = 32'h4004;
    dmem[0] = 32'h2000; dmem[1] = 32'h0000_0004;
    dmem[2] = 32'h3001; dmem[3] = 32'h0000_0002;
    dmem[4] = 32'h4000; dmem[5] = 32'h8000_0006;
    wb = wr_cnt; gb = given; rb = rd_cnt;
    quota = given + 6;
    launch(1'b1);
    wait_irq(200, "R6 to-mem irq");
    @(negedge clk);
    chk("R3 write count", wr_cnt - wb, 32'd6);
    for (int i = 0; i < 6; i++) begin
      chk("R3 write addr (R5 bit0)", wlog_a[(wb + i) % 64], ea[i]);
      chk("R3 write data", {16'h0, wlog_d[(wb + i) % 64]}, {16'h0, 16'h1000 + 16'(gb + i)});
    end
    chk("R2 first fetch", rdlog_a[rb % 64], DT);
    rd(3'd2, v); chk("R6 status done", v, 32'h04);
    wr(3'd0, 32'h0);
    wr(3'd2, 32'h00);
    rd(3'd2, v); chk("R7 write0 keeps intr", v, 32'h04);
    wr(3'd2, 32'h04);
    rd(3'd2, v); chk("R7 w1c intr", v, 32'h00);
    cleanup();
  endtask

  task automatic t_from_mem();
    logic [31:0] v;
    logic [31:0] ea [0:3];
    int wb, gb;
    ea[0] = 32'h6000; ea[1] = 32'h6002; ea[2] = 32'h6100; ea[3] = 32'h6200;
    dmem[0] = 32'h6000; dmem[1] = 32'h0000_0004;
    dmem[2] = 32'h6101; dmem[3] = 32'h0000_0002;
    dmem[4] = 32'h6200; dmem[5] = 32'h8000_0002;
    wb = wr_cnt; gb = given;
    quota = given + 4;
    launch(1'b0);
    wait_irq(200, "R6 from-mem irq");
    @(negedge clk);
    chk("R4 drive word count", given - gb, 32'd4);
    for (int i = 0; i < 4; i++)
      chk("R4 drive data", {16'h0, rlog[(gb + i) % 64]}, {16'h0, fdat(ea[i])});
    chk("R4 no mem writes", wr_cnt - wb, 32'd0);
    rd(3'd2, v); chk("R6 status 100b", v, 32'h04);
    cleanup();
  endtask

  task automatic t_cap();
    logic [31:0] v;
    wr(3'd2, 32'h60);
    rd(3'd2, v); chk("R8 cap write", v, 32'h60);
    dmem[0] = 32'h7000; dmem[1] = 32'h8000_0004;
    quota = given + 2;
    launch(1'b1);
    wait_irq(100, "R8 run irq");
    rd(3'd2, v); chk("R8 cap after run", v, 32'h64);
    wr(3'd0, 32'h0);
    wr(3'd2, 32'h64);
    rd(3'd2, v); chk("R8 cap after w1c", v, 32'h60);
    wr(3'd2, 32'h00);
    rd(3'd2, v); chk("R8 cap cleared", v, 32'h00);
    cleanup();
  endtask

  task automatic t_zero();
    int wb;
    dmem[0] = 32'h0001_0000; dmem[1] = 32'h8000_0000;
    wb = wr_cnt;
    quota = given + 32768;
    launch(1'b1);
    wait_irq(70000, "R5 zero-count irq");
    @(negedge clk);
    chk("R5 zero count words", wr_cnt - wb, 32'd32768);
    chk("R5 zero count last addr", wr_last, 32'h0001_FFFE);
    cleanup();
  endtask

  task automatic t_abort();
    logic [31:0] v;
    int wb;
    dmem[0] = 32'h8000; dmem[1] = 32'h8000_0100;
    quota = given + 1000;
    launch(1'b1);
    repeat (20) @(negedge clk);
    wr(3'd0, 32'h08);
    chk("R9 mem_valid drops", {31'b0, mem_valid}, 32'd0);
    rd(3'd2, v); chk("R9 status after abort", v, 32'h00);
    wb = wr_cnt;
    repeat (10) @(negedge clk);
    chk("R9 no traffic after abort", wr_cnt - wb, 32'd0);
    chk("R9 no irq", {31'b0, irq}, 32'd0);
    cleanup();
  endtask

  task automatic t_fault();
    logic [31:0] v;
    int wb, n;
    dmem[0] = 32'h5000; dmem[1] = 32'h8000_0008;
    err_addr = 32'h5004; err_en = 1'b1;
    wb = wr_cnt;
    quota = given + 4;
    launch(1'b1);
    n = 0;
    do begin
      rd(3'd2, v);
      n++;
    end while (v[0] != 1'b0 && n < 100);
    chk("R10 status fault", {29'b0, v[2:0]}, 32'h2);
    chk("R10 writes before fault", wr_cnt - wb, 32'd2);
    repeat (10) @(negedge clk);
    chk("R10 halted", wr_cnt - wb, 32'd2);
    chk("R10 no irq", {31'b0, irq}, 32'd0);
    cleanup();
  endtask

  task automatic t_overrun();
    logic [31:0] v;
    dmem[0] = 32'h9000; dmem[1] = 32'h8000_0004;
    quota = given + 3;
    launch(1'b1);
    wait_irq(100, "R11 irq");
    repeat (2) @(negedge clk);
    rd(3'd2, v); chk("R11 overrun error", {29'b0, v[2:0]}, 32'h6);
    cleanup();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 3'd0; reg_wdata = '0;
    err_en = 1'b0; err_addr = '0; quota = 0;
    for (int i = 0; i < 16; i++) dmem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_to_mem();
    t_from_mem();
    t_cap();
    t_abort();
    t_fault();
    t_overrun();
    t_zero();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule